// File: doc/BRIEF.md
# Dual-Mode Colour Palette Lookup

This block turns a pixel index into 6-bit red, green and blue levels by looking it up in one of two colour tables. The small table holds 16 entries of 12 bits: each 4-bit intensity is stored with a rotated bit order. The large table holds 256 entries, each with three 6-bit channels. A true-colour setting skips both tables and expands a 16-bit RGB565 pixel straight onto the outputs.

Software reaches both tables and the two mode registers through one byte-wide port on an 11-bit byte address. Writing the legacy mode byte switches lookups to the small table. Writing either byte of the extended mode register switches them to the large table. The extended mode holds a 4-bit bank that picks a group of 16 large-table entries in 16-colour operation. It also holds an 8-bit-index flag, a 2-colour flag and the true-colour flag. Lookups and reads both return their result one clock after the request.

Top module: `dual_palette_lut`

## Requirements
- R1: Small-table entry k sits at byte addresses 2k (bits 3:0 hold red, bits 7:4 are dropped) and 2k+1 (bits 7:4 hold green, bits 3:0 hold blue).
- R2: A stored 4-bit field n has the intensity LSB in n[3] and intensity bits 3:1 in n[2:0]. The 4-bit level L = {n[2:0], n[3]} is output as {L, L[3:2]}.
- R3: Large-table entry k occupies bytes 0x400+4k+0 (red), +1 (green), +2 (unused: writes dropped, reads 0) and +3 (blue). Each channel is taken from and returned in bits 7:2 of its byte.
- R4: The legacy mode byte is at 0x020, bits 1:0. Value 01 uses pix_idx[1:0], 10 uses pix_idx[0], and 00 or 11 use pix_idx[3:0], zero-extended into the small table.
- R5: When the large table is selected and both the 8-bit flag and the 2-colour flag are clear, entry bank*16 + pix_idx[3:0] is used. The bank is bits 3:0 of the extended low byte at 0x023.
- R6: The 8-bit flag (bit 4 of 0x023) uses entry pix_idx[7:0]. Otherwise the 2-colour flag (bit 2 of 0x022) uses entry pix_idx[0].
- R7: Reset selects the small table. A write to 0x020 selects the small table, and a write to 0x022 or 0x023 selects the large table.
- R8: When the large table is selected and the true-colour flag (bit 0 of 0x022) is set, the tables are bypassed. Red is {p[15:11], p[15]}, green is p[10:5] and blue is {p[4:0], p[4]}. This flag takes priority over the 8-bit and 2-colour flags.
- R9: The colour outputs change one clock after pix_idx. A table write on the same edge does not affect that lookup, which returns the entry's old contents.
- R10: A read returns its byte one clock later. The byte holds only the stored bits, with unused bits 0. Unmapped addresses read 0, and bus_rdata is 0 in any cycle after no read was requested. Mode reads return 0x020 = {6'b0, depth}, 0x022 = {5'b0, mono, 1'b0, tc} and 0x023 = {3'b0, eight, bank}.
- R11: Synchronous reset clears both tables, all mode fields and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 11 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after bus_rd |
| pix_idx | input | 16 | Pixel index, or RGB565 pixel in true-colour mode |
| red_out | output | 6 | Red level |
| grn_out | output | 6 | Green level |
| blu_out | output | 6 | Blue level |

## Verification
The checker asserts on every cycle the properties that hold regardless of table contents. These are:
- an idle read port returns zero;
- the unused byte of a large-table entry and the two low bits of every large-table channel read zero;
- each mode-register write selects the right table;
- small-table outputs always carry the replicated top bits;
- true-colour red and blue carry the replicated MSB.

Only the bench's scenarios can show the rest, because it depends on what has been stored:
- the nibble rotation and the byte packing of entries;
- bank and depth index selection, including masking of the unused pixel bits;
- the old-value result when a lookup and a write to the same entry share a clock edge.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

    localparam int CH_W  = 6;
    localparam int NIB_W = 4;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        DEPTH_16  = 2'b00,
        DEPTH_4   = 2'b01,
        DEPTH_2   = 2'b10,
        DEPTH_RSV = 2'b11
    } leg_depth_e;

    typedef enum logic [1:0] {
        LANE_RED = 2'd0,
        LANE_GRN = 2'd1,
        LANE_PAD = 2'd2,
        LANE_BLU = 2'd3
    } ext_lane_e;

    typedef struct packed {
        logic       tc;
        logic       mono;
        logic       eight;
        logic [3:0] bank;
    } ext_mode_t;

    // Stored nibble keeps the level LSB in its top bit.
    function automatic logic [CH_W-1:0] leg_expand(input logic [NIB_W-1:0] nib);
        logic [NIB_W-1:0] lvl;
        lvl = {nib[2:0], nib[3]};
        return {lvl, lvl[NIB_W-1:NIB_W-2]};
    endfunction

    function automatic logic [CH_W-1:0] five_to_six(input logic [4:0] v);
        return {v, v[4]};
    endfunction

endpackage

// File: rtl/dpl_legacy_pal.sv
module dpl_legacy_pal
    import dpl_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IW = $clog2(ENTRIES),
    localparam int BW = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [BW-1:0] addr,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] lk_idx,
    output rgb_t          lk_rgb,
    output logic [7:0]    rd_byte
);

    logic [NIB_W-1:0] red_arr [ENTRIES];
    logic [NIB_W-1:0] grn_arr [ENTRIES];
    logic [NIB_W-1:0] blu_arr [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic             hit;
        logic [NIB_W-1:0] r_q, g_q, b_q;

        assign hit = wr_en && (addr[BW-1:1] == IW'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
                g_q <= '0;
                b_q <= '0;
            end else if (hit) begin
                if (!addr[0]) begin
                    r_q <= wr_data[3:0];
                end else begin
                    g_q <= wr_data[7:4];
                    b_q <= wr_data[3:0];
                end
            end
        end

        assign red_arr[e] = r_q;
        assign grn_arr[e] = g_q;
        assign blu_arr[e] = b_q;
    end

    always_comb begin
        lk_rgb.r = leg_expand(red_arr[lk_idx]);
        lk_rgb.g = leg_expand(grn_arr[lk_idx]);
        lk_rgb.b = leg_expand(blu_arr[lk_idx]);
    end

    always_comb begin
        if (addr[0]) begin
            rd_byte = {grn_arr[addr[BW-1:1]], blu_arr[addr[BW-1:1]]};
        end else begin
            rd_byte = {4'b0000, red_arr[addr[BW-1:1]]};
        end
    end

endmodule

// File: rtl/dpl_ext_pal.sv
module dpl_ext_pal
    import dpl_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IW = $clog2(ENTRIES),
    localparam int BW = IW + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [BW-1:0]   addr,
    input  logic [CH_W-1:0] wr_chan,
    input  logic [IW-1:0]   lk_idx,
    output rgb_t            lk_rgb,
    output logic [7:0]      rd_byte
);

    localparam int PAD_W = 8 - CH_W;

    logic [CH_W-1:0] red_arr [ENTRIES];
    logic [CH_W-1:0] grn_arr [ENTRIES];
    logic [CH_W-1:0] blu_arr [ENTRIES];
    ext_lane_e       lane;
    logic [IW-1:0]   ent;

    assign lane = ext_lane_e'(addr[1:0]);
    assign ent  = addr[BW-1:2];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic            hit;
        logic [CH_W-1:0] r_q, g_q, b_q;

        assign hit = wr_en && (ent == IW'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
                g_q <= '0;
                b_q <= '0;
            end else if (hit) begin
                case (lane)
                    LANE_RED: r_q <= wr_chan;
                    LANE_GRN: g_q <= wr_chan;
                    LANE_BLU: b_q <= wr_chan;
                    default:  ;
                endcase
            end
        end

        assign red_arr[e] = r_q;
        assign grn_arr[e] = g_q;
        assign blu_arr[e] = b_q;
    end

    always_comb begin
        lk_rgb.r = red_arr[lk_idx];
        lk_rgb.g = grn_arr[lk_idx];
        lk_rgb.b = blu_arr[lk_idx];
    end

    always_comb begin
        case (lane)
            LANE_RED: rd_byte = {red_arr[ent], {PAD_W{1'b0}}};
            LANE_GRN: rd_byte = {grn_arr[ent], {PAD_W{1'b0}}};
            LANE_BLU: rd_byte = {blu_arr[ent], {PAD_W{1'b0}}};
            default:  rd_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/dpl_mode_ctl.sv
module dpl_mode_ctl
    import dpl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       leg_wr,
    input  logic       ext_hi_wr,
    input  logic       ext_lo_wr,
    input  logic [1:0] depth_in,
    input  logic       tc_in,
    input  logic       mono_in,
    input  logic [4:0] lo_in,
    output logic       use_ext,
    output leg_depth_e leg_depth,
    output ext_mode_t  ext_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            use_ext   <= 1'b0;
            leg_depth <= DEPTH_16;
            ext_mode  <= '0;
        end else begin
            if (leg_wr) begin
                leg_depth <= leg_depth_e'(depth_in);
                use_ext   <= 1'b0;
            end
            if (ext_hi_wr) begin
                ext_mode.tc   <= tc_in;
                ext_mode.mono <= mono_in;
                use_ext       <= 1'b1;
            end
            if (ext_lo_wr) begin
                ext_mode.eight <= lo_in[4];
                ext_mode.bank  <= lo_in[3:0];
                use_ext        <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_palette_lut.sv
module dual_palette_lut
    import dpl_pkg::*;
#(
    parameter int LEG_ENTRIES = 16,
    parameter int EXT_ENTRIES = 256,
    parameter int PIX_W       = 16,
    parameter int ADDR_W      = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [PIX_W-1:0]  pix_idx,
    output logic [CH_W-1:0]   red_out,
    output logic [CH_W-1:0]   grn_out,
    output logic [CH_W-1:0]   blu_out
);

    localparam int LEG_IW = $clog2(LEG_ENTRIES);
    localparam int EXT_IW = $clog2(EXT_ENTRIES);
    localparam int LEG_BW = LEG_IW + 1;
    localparam int EXT_BW = EXT_IW + 2;
    localparam logic [ADDR_W-1:0] LEG_MODE_A = ADDR_W'(2 * LEG_ENTRIES);
    localparam logic [ADDR_W-1:0] EXT_HI_A   = ADDR_W'(2 * LEG_ENTRIES + 2);
    localparam logic [ADDR_W-1:0] EXT_LO_A   = ADDR_W'(2 * LEG_ENTRIES + 3);

    // Address decode
    logic ext_hit, leg_hit, legm_hit, exthi_hit, extlo_hit;

    assign ext_hit   = bus_addr[ADDR_W-1];
    assign leg_hit   = !ext_hit && (bus_addr[ADDR_W-2:LEG_BW] == '0);
    assign legm_hit  = (bus_addr == LEG_MODE_A);
    assign exthi_hit = (bus_addr == EXT_HI_A);
    assign extlo_hit = (bus_addr == EXT_LO_A);

    // Mode state
    logic       use_ext;
    leg_depth_e leg_depth;
    ext_mode_t  ext_mode;

    dpl_mode_ctl u_mode (
        .clk      (clk),
        .rst      (rst),
        .leg_wr   (bus_wr && legm_hit),
        .ext_hi_wr(bus_wr && exthi_hit),
        .ext_lo_wr(bus_wr && extlo_hit),
        .depth_in (bus_wdata[1:0]),
        .tc_in    (bus_wdata[0]),
        .mono_in  (bus_wdata[2]),
        .lo_in    (bus_wdata[4:0]),
        .use_ext  (use_ext),
        .leg_depth(leg_depth),
        .ext_mode (ext_mode)
    );

    // Index selection
    logic [LEG_IW-1:0] leg_idx;
    logic [EXT_IW-1:0] ext_idx;

    always_comb begin
        case (leg_depth)
            DEPTH_4: leg_idx = LEG_IW'(pix_idx[1:0]);
            DEPTH_2: leg_idx = LEG_IW'(pix_idx[0]);
            default: leg_idx = pix_idx[LEG_IW-1:0];
        endcase
    end

    always_comb begin
        if (ext_mode.eight) begin
            ext_idx = pix_idx[EXT_IW-1:0];
        end else if (ext_mode.mono) begin
            ext_idx = EXT_IW'(pix_idx[0]);
        end else begin
            ext_idx = EXT_IW'({ext_mode.bank, pix_idx[LEG_IW-1:0]});
        end
    end

    // Tables
    rgb_t       leg_rgb, ext_rgb, tc_rgb, sel_rgb;
    logic [7:0] leg_rd, ext_rd;

    dpl_legacy_pal #(.ENTRIES(LEG_ENTRIES)) u_leg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr && leg_hit),
        .addr   (bus_addr[LEG_BW-1:0]),
        .wr_data(bus_wdata),
        .lk_idx (leg_idx),
        .lk_rgb (leg_rgb),
        .rd_byte(leg_rd)
    );

    dpl_ext_pal #(.ENTRIES(EXT_ENTRIES)) u_ext (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr && ext_hit),
        .addr   (bus_addr[EXT_BW-1:0]),
        .wr_chan(bus_wdata[7:8-CH_W]),
        .lk_idx (ext_idx),
        .lk_rgb (ext_rgb),
        .rd_byte(ext_rd)
    );

    // True-colour bypass
    always_comb begin
        tc_rgb.r = five_to_six(pix_idx[15:11]);
        tc_rgb.g = pix_idx[10:5];
        tc_rgb.b = five_to_six(pix_idx[4:0]);
    end

    always_comb begin
        if (!use_ext) begin
            sel_rgb = leg_rgb;
        end else if (ext_mode.tc) begin
            sel_rgb = tc_rgb;
        end else begin
            sel_rgb = ext_rgb;
        end
    end

    // Read mux
    logic [7:0] rd_next;

    always_comb begin
        rd_next = 8'h00;
        if (bus_rd) begin
            if (ext_hit) begin
                rd_next = ext_rd;
            end else if (leg_hit) begin
                rd_next = leg_rd;
            end else if (legm_hit) begin
                rd_next = {6'b0, leg_depth};
            end else if (exthi_hit) begin
                rd_next = {5'b0, ext_mode.mono, 1'b0, ext_mode.tc};
            end else if (extlo_hit) begin
                rd_next = {3'b0, ext_mode.eight, ext_mode.bank};
            end
        end
    end

    // Output registers
    rgb_t rgb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_q     <= '0;
            bus_rdata <= 8'h00;
        end else begin
            rgb_q     <= sel_rgb;
            bus_rdata <= rd_next;
        end
    end

    assign red_out = rgb_q.r;
    assign grn_out = rgb_q.g;
    assign blu_out = rgb_q.b;

endmodule

// File: rtl/dpl_checker.sv
module dpl_checker #(
    parameter int ADDR_W      = 11,
    parameter int LEG_ENTRIES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic [5:0]        red_out,
    input logic [5:0]        grn_out,
    input logic [5:0]        blu_out,
    input logic              use_ext,
    input logic              ext_tc
);

    localparam logic [ADDR_W-1:0] LEG_MODE_A = ADDR_W'(2 * LEG_ENTRIES);
    localparam logic [ADDR_W-1:0] EXT_HI_A   = ADDR_W'(2 * LEG_ENTRIES + 2);
    localparam logic [ADDR_W-1:0] EXT_LO_A   = ADDR_W'(2 * LEG_ENTRIES + 3);

    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 8'h00));

    // R3
    pad_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[ADDR_W-1] && (bus_addr[1:0] == 2'b10)) |=> (bus_rdata == 8'h00));

    // R10
    chan_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[ADDR_W-1]) |=> (bus_rdata[1:0] == 2'b00));

    // R7
    leg_select_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == LEG_MODE_A)) |=> !use_ext);

    // R7
    ext_select_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ((bus_addr == EXT_HI_A) || (bus_addr == EXT_LO_A))) |=> use_ext);

    // R2
    leg_replicate_chk: assert property (@(posedge clk) disable iff (rst)
        !use_ext |=> ((red_out[1:0] == red_out[5:4]) && (grn_out[1:0] == grn_out[5:4])
                      && (blu_out[1:0] == blu_out[5:4])));

    // R8
    tc_replicate_chk: assert property (@(posedge clk) disable iff (rst)
        (use_ext && ext_tc) |=> ((red_out[0] == red_out[5]) && (blu_out[0] == blu_out[5])));

endmodule

bind dual_palette_lut dpl_checker #(.ADDR_W(ADDR_W), .LEG_ENTRIES(LEG_ENTRIES)) chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .red_out  (red_out),
    .grn_out  (grn_out),
    .blu_out  (blu_out),
    .use_ext  (use_ext),
    .ext_tc   (ext_mode.tc)
);

// File: tb/dual_palette_lut_test.sv
module dual_palette_lut_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] pix_idx = '0;
    logic [7:0]  bus_rdata;
    logic [5:0]  red_out, grn_out, blu_out;

    always #10 clk = ~clk;

    dual_palette_lut uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .red_out(red_out), .grn_out(grn_out), .blu_out(blu_out)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int m_lr[16], m_lg[16], m_lb[16];
    int m_er[256], m_eg[256], m_eb[256];
    int m_ext, m_depth, m_tc, m_mono, m_eight, m_bank;

    function automatic int lvl6(int nib);
        int l;
        l = ((nib & 7) * 2) + ((nib / 8) & 1);
        return l * 4 + l / 4;
    endfunction

    function automatic int x5(int v);
        return v * 2 + v / 16;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin m_lr[i] = 0; m_lg[i] = 0; m_lb[i] = 0; end
        for (int i = 0; i < 256; i++) begin m_er[i] = 0; m_eg[i] = 0; m_eb[i] = 0; end
        m_ext = 0; m_depth = 0; m_tc = 0; m_mono = 0; m_eight = 0; m_bank = 0;
    endtask

    task automatic tick(string tag);
        int er, eg, eb, erd, idx, a, p, d, e;
        a = int'(bus_addr);
        p = int'(pix_idx);
        d = int'(bus_wdata);
        er = 0; eg = 0; eb = 0; erd = 0;
        if (!rst) begin
            if (m_ext != 0) begin
                if (m_tc != 0) begin
                    er = x5((p / 2048) % 32); eg = (p / 32) % 64; eb = x5(p % 32);
                end else begin
                    if (m_eight != 0) idx = p % 256;
                    else if (m_mono != 0) idx = p % 2;
                    else idx = m_bank * 16 + p % 16;
                    er = m_er[idx]; eg = m_eg[idx]; eb = m_eb[idx];
                end
            end else begin
                if (m_depth == 1) idx = p % 4;
                else if (m_depth == 2) idx = p % 2;
                else idx = p % 16;
                er = lvl6(m_lr[idx]); eg = lvl6(m_lg[idx]); eb = lvl6(m_lb[idx]);
            end
            if (bus_rd) begin
                if (a < 32) erd = (a % 2 == 0) ? m_lr[a / 2] : m_lg[a / 2] * 16 + m_lb[a / 2];
                else if (a == 32) erd = m_depth;
                else if (a == 34) erd = m_mono * 4 + m_tc;
                else if (a == 35) erd = m_eight * 16 + m_bank;
                else if (a >= 1024) begin
                    e = (a - 1024) / 4;
                    case (a % 4)
                        0: erd = m_er[e] * 4;
                        1: erd = m_eg[e] * 4;
                        3: erd = m_eb[e] * 4;
                        default: erd = 0;
                    endcase
                end
            end
        end
        if (rst) model_reset();
        else if (bus_wr) begin
            if (a < 32) begin
                if (a % 2 == 0) m_lr[a / 2] = d % 16;
                else begin m_lg[a / 2] = d / 16; m_lb[a / 2] = d % 16; end
            end else if (a == 32) begin m_depth = d % 4; m_ext = 0; end
            else if (a == 34) begin m_tc = d % 2; m_mono = (d / 4) % 2; m_ext = 1; end
            else if (a == 35) begin m_bank = d % 16; m_eight = (d / 16) % 2; m_ext = 1; end
            else if (a >= 1024) begin
                e = (a - 1024) / 4;
                if (a % 4 == 0) m_er[e] = d / 4;
                else if (a % 4 == 1) m_eg[e] = d / 4;
                else if (a % 4 == 3) m_eb[e] = d / 4;
            end
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (int'(red_out) != er || int'(grn_out) != eg || int'(blu_out) != eb || int'(bus_rdata) != erd) begin
            errors++;
            $display("FAIL %s: actual rgb=%0d/%0d/%0d rd=%0d expected rgb=%0d/%0d/%0d rd=%0d",
                     tag, red_out, grn_out, blu_out, bus_rdata, er, eg, eb, erd);
        end
    endtask

    task automatic wr(int a, int d, string tag);
        bus_wr = 1'b1; bus_addr = 11'(a); bus_wdata = 8'(d);
        tick(tag);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        bus_rd = 1'b1; bus_addr = 11'(a);
        tick(tag);
        bus_rd = 1'b0;
    endtask

    task automatic look(int p, string tag);
        pix_idx = 16'(p);
        tick(tag);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=60000 cycles expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        pix_idx = 16'h1234;
        repeat (3) tick("R11");
        rst = 1'b0;
        look(16'hFFFF, "R11");
        rd(1, "R11");
        rd(35, "R11");

        // Small table: upper nibble of even byte is junk
        for (int k = 0; k < 16; k++) begin
            wr(2 * k, 8'hF0 | k, "R1");
            wr(2 * k + 1, (k * 37 + 90) % 256, "R1");
        end
        for (int k = 0; k < 4; k++) rd(2 * k + k % 2, "R10");
        for (int k = 0; k < 16; k++) look(16'hABC0 | k, "R2");

        wr(32, 1, "R4");
        for (int k = 0; k < 8; k++) look(16'hF0F0 | k, "R4");
        wr(32, 2, "R4");
        for (int k = 0; k < 4; k++) look(16'h5550 | k, "R4");
        wr(32, 3, "R4");
        for (int k = 0; k < 4; k++) look(16'h0030 | (k * 5), "R4");
        wr(32, 0, "R4");

        // Lookup on the same edge as a write to that entry
        pix_idx = 16'd3;
        wr(7, 8'h5A, "R9");
        look(3, "R9");
        wr(6, 8'h07, "R9");
        look(3, "R9");

        // Large table
        for (int k = 0; k < 256; k++) begin
            wr(1024 + 4 * k, (k * 5 + 1) % 256, "R3");
            wr(1024 + 4 * k + 1, (k * 11 + 7) % 256, "R3");
            wr(1024 + 4 * k + 2, 8'hAA, "R3");
            wr(1024 + 4 * k + 3, (255 - (k * 3) % 256), "R3");
        end
        look(5, "R7");

        wr(35, 8'h05, "R7");
        for (int k = 0; k < 16; k++) look(16'h7FF0 | k, "R5");
        wr(35, 8'h0F, "R5");
        for (int k = 0; k < 4; k++) look(16'h1230 | (k * 4), "R5");

        wr(35, 8'h10, "R6");
        for (int k = 0; k < 16; k++) look((k * 2929 + 3) % 65536, "R6");
        wr(35, 8'h00, "R6");
        wr(34, 8'h04, "R6");
        for (int k = 0; k < 4; k++) look(16'hFFF0 | k, "R6");

        wr(34, 8'h05, "R8");
        look(16'hF800, "R8");
        look(16'h07E0, "R8");
        look(16'h001F, "R8");
        look(16'h1234, "R8");
        look(16'hFFFF, "R8");
        wr(35, 8'h10, "R8");
        look(16'h8421, "R8");
        rd(34, "R10");
        wr(34, 8'hFA, "R10");
        rd(34, "R10");
        rd(35, "R10");

        wr(32, 8'h00, "R7");
        look(5, "R7");
        rd(32, "R10");

        rd(1024 + 36, "R3");
        rd(1024 + 37, "R3");
        rd(1024 + 38, "R3");
        rd(1024 + 39, "R3");
        rd(48, "R10");
        rd(33, "R10");
        tick("R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule